// File: doc/BRIEF.md
# S/PDIF Channel-Status Block Generator

This block produces the channel-status bit stream that an S/PDIF transmitter inserts into each subframe. A set of configuration inputs describes the outgoing stream: a non-audio flag, an 8-bit category code, a 4-bit source number, separate 4-bit channel numbers for the left and right subframes, a 4-bit sampling-frequency code, a maximum-word-length flag and a 3-bit word-length code. A professional-mode flag input is also present, but it is overridden because only consumer-mode blocks are produced. These fields are placed into a 192-bit block. Only the low 40 bit positions can carry data, and every other position is sent as zero.

The framer pulses `sub_req` once for each subframe it is about to send and sets `sub_right` to say which side the subframe is. On the clock edge that sees the request, the block registers the status bit for that subframe onto `cs_bit`. For the left subframe of frame 0 it also raises `blk_start`, which tells the framer to use the block-start preamble. Both outputs hold until the next accepted request. The configuration inputs are copied into a shadow register when frame 0 begins, so every block is sent with one consistent set of field values.

A three-state sequencer controls the frame position:

- `CS_IDLE` is the state after reset.
  - A left request moves it to `CS_WAIT_RIGHT` and loads the shadow.
  - A right request is ignored.
- `CS_WAIT_RIGHT` means the left half of the current frame has been sent.
  - A right request advances the frame index and moves to `CS_WAIT_LEFT`.
  - A repeated left request resends the same frame and stays.
- `CS_WAIT_LEFT` means the frame is complete.
  - A left request moves to `CS_WAIT_RIGHT` and reloads the shadow if the index is 0.
  - A right request with no left request before it still advances the index and stays.

Top module: `spdif_cs_gen`

## Requirements
- R1: After reset `cs_bit` and `blk_start` are 0 and the sequencer is in `CS_IDLE` with frame index 0; the same holds after a reset applied in the middle of a block.
- R2: `blk_start` is 1 after an accepted left request for frame 0 and is 0 after every other accepted request, including every right request.
- R3: The frame index advances by one on each accepted right request and wraps from 191 to 0. A block therefore lasts 192 frames, and the next block begins with a left request that gives `blk_start` = 1.
- R4: Status bit 0 is always sent as 0, whatever the value of `cfg_pro`.
- R5: Status bit 1 equals `cfg_nonaudio`.
- R6: Status bits 8 to 15 carry `cfg_category`, with its bit 0 at status bit 8. Status bits 16 to 19 carry `cfg_source`, with its bit 0 at status bit 16.
- R7: Status bits 20 to 23 carry `cfg_chan_left` in left subframes and `cfg_chan_right` in right subframes, with bit 0 of the field at status bit 20. Every other status bit is identical in the two subframes of a frame.
- R8: Status bits 24 to 27 carry `cfg_fs_code`, with its bit 0 at status bit 24. Status bit 32 equals `cfg_max_wl`. Status bits 33 to 35 carry `cfg_wl_code`, with its bit 0 at status bit 33.
- R9: Status bits 2 to 7, 28 to 31 and 36 to 191 are sent as 0.
- R10: Configuration inputs are sampled only when a left request is accepted at frame index 0. A change made during a block does not affect that block's remaining bits.
- R11: A right request in `CS_IDLE` leaves both outputs and the frame index unchanged, and the next left request still starts a block.
- R12: A second left request in the same frame resends that frame's bit without advancing the index. The following right and left requests continue from that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_req | input | 1 | One-cycle strobe, one per subframe |
| sub_right | input | 1 | 1 = right subframe, 0 = left subframe |
| cfg_pro | input | 1 | Professional flag (overridden to 0) |
| cfg_nonaudio | input | 1 | Payload is not linear PCM |
| cfg_category | input | 8 | Category code |
| cfg_source | input | 4 | Source number |
| cfg_chan_left | input | 4 | Channel number for left subframes (0 = unused) |
| cfg_chan_right | input | 4 | Channel number for right subframes (0 = unused) |
| cfg_fs_code | input | 4 | Sampling-frequency code |
| cfg_max_wl | input | 1 | Maximum word length: 0 = 20 bits, 1 = 24 bits |
| cfg_wl_code | input | 3 | Word-length code, 000 = not indicated |
| cs_bit | output | 1 | Status bit for the last accepted subframe |
| blk_start | output | 1 | Last accepted subframe is the left subframe of frame 0 |

## Verification
A frame index that has slipped shows up on the first request after the slip: `blk_start` appears one frame early or late, or it appears on a right subframe. Within at most 36 frames the populated fields then show up shifted by one or more positions. A shadow register that was loaded at the wrong moment shows up as changed field bits within the same block, at the first populated position after the configuration change. A sequencer stuck in the wrong state shows up either as a repeated or skipped frame when a left request is doubled, or as `blk_start` missing after reset.

// File: rtl/spdif_cs_pkg.sv
`timescale 1ns/1ps
package spdif_cs_pkg;

    typedef enum logic [1:0] {
        CS_IDLE       = 2'd0,
        CS_WAIT_RIGHT = 2'd1,
        CS_WAIT_LEFT  = 2'd2
    } cs_state_e;

    typedef struct packed {
        logic       nonaudio;
        logic [7:0] category;
        logic [3:0] source;
        logic [3:0] chan_l;
        logic [3:0] chan_r;
        logic [3:0] fs_code;
        logic       max_wl;
        logic [2:0] wl_code;
    } cs_cfg_t;

    // Field positions decoded by the receiver: fixed by the stream format.
    localparam int POS_NONAUDIO = 1;
    localparam int POS_CATEGORY = 8;
    localparam int POS_SOURCE   = 16;
    localparam int POS_CHANNEL  = 20;
    localparam int POS_FS       = 24;
    localparam int POS_MAXWL    = 32;
    localparam int POS_WLCODE   = 33;
    localparam int FIELD_TOP    = 36;

endpackage

// File: rtl/cs_frame_seq.sv
`timescale 1ns/1ps
module cs_frame_seq
    import spdif_cs_pkg::*;
#(
    parameter int BLOCK_LEN = 192,
    parameter int IDX_W     = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             right,
    output logic [IDX_W-1:0] idx_o,
    output logic             accept_o,
    output logic             load_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCK_LEN - 1);

    cs_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             advance;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:       if (req && !right) state_d = CS_WAIT_RIGHT;
            CS_WAIT_RIGHT: if (req &&  right) state_d = CS_WAIT_LEFT;
            CS_WAIT_LEFT:  if (req && !right) state_d = CS_WAIT_RIGHT;
            default:       state_d = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs per state
    always_comb begin
        accept_o = 1'b0;
        load_o   = 1'b0;
        advance  = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                accept_o = req && !right;
                load_o   = req && !right;
            end
            CS_WAIT_RIGHT, CS_WAIT_LEFT: begin
                accept_o = req;
                load_o   = req && !right && (idx_q == '0);
                advance  = req && right;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (advance) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    assign idx_o = idx_q;

    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CS_IDLE && req && right && idx_q == LAST) |=> (idx_q == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CS_IDLE && req && right && idx_q != LAST)
            |=> (idx_q == $past(idx_q) + 1'b1));

    p_left_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !right) |=> $stable(idx_q));

    p_idle_right_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_IDLE && req && right) |=> (state_q == CS_IDLE && idx_q == '0));

    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {CS_IDLE, CS_WAIT_RIGHT, CS_WAIT_LEFT});

endmodule

// File: rtl/cs_field_map.sv
`timescale 1ns/1ps
module cs_field_map
    import spdif_cs_pkg::*;
#(
    parameter int USED_BITS = 40,
    parameter int IDX_W     = 8
) (
    input  cs_cfg_t          cfg_i,
    input  logic             right_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);

    localparam int VEC_IW  = $clog2(USED_BITS);
    localparam int VEC_LEN = 1 << VEC_IW;

    generate
        if (USED_BITS < FIELD_TOP || VEC_IW > IDX_W) begin : g_bad_size
            $error("populated region too small for the status fields");
        end
    endgenerate

    logic [VEC_LEN-1:0] image;
    logic [3:0]         chan;

    always_comb begin
        chan  = right_i ? cfg_i.chan_r : cfg_i.chan_l;
        image = '0;
        // bit 0 stays 0: only consumer-mode blocks are produced
        image[POS_NONAUDIO]       = cfg_i.nonaudio;
        image[POS_CATEGORY +: 8]  = cfg_i.category;
        image[POS_SOURCE   +: 4]  = cfg_i.source;
        image[POS_CHANNEL  +: 4]  = chan;
        image[POS_FS       +: 4]  = cfg_i.fs_code;
        image[POS_MAXWL]          = cfg_i.max_wl;
        image[POS_WLCODE   +: 3]  = cfg_i.wl_code;
        bit_o = 1'b0;
        if (idx_i < IDX_W'(USED_BITS)) bit_o = image[idx_i[VEC_IW-1:0]];
    end

endmodule

// File: rtl/spdif_cs_gen.sv
`timescale 1ns/1ps
module spdif_cs_gen
    import spdif_cs_pkg::*;
#(
    parameter int BLOCK_LEN = 192,
    parameter int USED_BITS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_req,
    input  logic       sub_right,
    input  logic       cfg_pro,
    input  logic       cfg_nonaudio,
    input  logic [7:0] cfg_category,
    input  logic [3:0] cfg_source,
    input  logic [3:0] cfg_chan_left,
    input  logic [3:0] cfg_chan_right,
    input  logic [3:0] cfg_fs_code,
    input  logic       cfg_max_wl,
    input  logic [2:0] cfg_wl_code,
    output logic       cs_bit,
    output logic       blk_start
);

    localparam int IDX_W = $clog2(BLOCK_LEN);

    cs_cfg_t          live_cfg, shadow_q;
    logic [IDX_W-1:0] idx;
    logic             accept, load, map_bit;

    always_comb begin
        live_cfg.nonaudio = cfg_nonaudio;
        live_cfg.category = cfg_category;
        live_cfg.source   = cfg_source;
        live_cfg.chan_l   = cfg_chan_left;
        live_cfg.chan_r   = cfg_chan_right;
        live_cfg.fs_code  = cfg_fs_code;
        live_cfg.max_wl   = cfg_max_wl;
        live_cfg.wl_code  = cfg_wl_code;
    end

    cs_frame_seq #(.BLOCK_LEN(BLOCK_LEN), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (sub_req),
        .right    (sub_right),
        .idx_o    (idx),
        .accept_o (accept),
        .load_o   (load)
    );

    cs_field_map #(.USED_BITS(USED_BITS), .IDX_W(IDX_W)) u_map (
        .cfg_i   (shadow_q),
        .right_i (sub_right),
        .idx_i   (idx),
        .bit_o   (map_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            cs_bit    <= 1'b0;
            blk_start <= 1'b0;
        end else begin
            if (load) shadow_q <= live_cfg;
            if (accept) begin
                cs_bit    <= map_bit;
                blk_start <= (idx == '0) && !sub_right;
            end
        end
    end

    p_tail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && idx >= IDX_W'(USED_BITS)) |=> !cs_bit);

    p_pro_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && idx == '0 && cfg_pro) |=> !cs_bit);

    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow_q));

    p_right_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sub_right) |=> !blk_start);

endmodule

// File: tb/sim_spdif_cs_gen.sv
`timescale 1ns/1ps
module sim_spdif_cs_gen;

    // {pro, nonaudio, category[7:0], source[3:0], chan_l, chan_r, fs[3:0], max_wl, wl[2:0]}
    localparam logic [29:0] VEC [4] = '{
        {1'b0, 1'b0, 8'hA5, 4'h3, 4'h1, 4'h2, 4'h2, 1'b1, 3'b101},
        {1'b1, 1'b1, 8'h3C, 4'hE, 4'h0, 4'hF, 4'hA, 1'b0, 3'b010},
        {1'b1, 1'b0, 8'hFF, 4'hF, 4'h9, 4'h6, 4'hF, 1'b1, 3'b111},
        {1'b0, 1'b1, 8'h00, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 3'b000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sub_req = 1'b0, sub_right = 1'b0;
    logic [29:0] cfg = '0;
    logic cs_bit, blk_start;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spdif_cs_gen u0 (
        .clk(clk), .rst_n(rst_n), .sub_req(sub_req), .sub_right(sub_right),
        .cfg_pro(cfg[29]), .cfg_nonaudio(cfg[28]), .cfg_category(cfg[27:20]),
        .cfg_source(cfg[19:16]), .cfg_chan_left(cfg[15:12]), .cfg_chan_right(cfg[11:8]),
        .cfg_fs_code(cfg[7:4]), .cfg_max_wl(cfg[3]), .cfg_wl_code(cfg[2:0]),
        .cs_bit(cs_bit), .blk_start(blk_start)
    );

    function automatic logic exp_bit(logic [29:0] v, logic right, int idx);
        logic [3:0] ch;
        ch = right ? v[11:8] : v[15:12];
        if (idx == 1)                return v[28];
        if (idx >= 8  && idx <= 15)  return v[20 + idx - 8];
        if (idx >= 16 && idx <= 19)  return v[16 + idx - 16];
        if (idx >= 20 && idx <= 23)  return ch[idx - 20];
        if (idx >= 24 && idx <= 27)  return v[4 + idx - 24];
        if (idx == 32)               return v[3];
        if (idx >= 33 && idx <= 35)  return v[idx - 33];
        return 1'b0;
    endfunction

    function automatic string field_tag(int idx);
        if (idx == 0)                return "R4";
        if (idx == 1)                return "R5";
        if (idx >= 8 && idx <= 19)   return "R6";
        if (idx >= 20 && idx <= 23)  return "R7";
        if ((idx >= 24 && idx <= 27) || (idx >= 32 && idx <= 35)) return "R8";
        return "R9";
    endfunction

    task automatic check(logic got, logic exp, string tag);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic send(logic right);
        @(negedge clk);
        sub_req = 1'b1;
        sub_right = right;
        @(negedge clk);
        sub_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_bit, 1'b0, "R1 reset cs_bit");
        check(blk_start, 1'b0, "R1 reset blk_start");

        // R11: right request while idle is ignored
        cfg = VEC[0];
        send(1'b1);
        check(cs_bit, 1'b0, "R11 idle right cs_bit");
        check(blk_start, 1'b0, "R11 idle right blk_start");

        // Table walk: one full block per vector, config disturbed at frame 5 (R10)
        for (int v = 0; v < 4; v++) begin
            cfg = VEC[v];
            for (int f = 0; f < 192; f++) begin
                if (f == 5) cfg = ~VEC[(v + 1) % 4];
                send(1'b0);
                check(blk_start, (f == 0), (f == 0) ? "R2 block start" : "R3 no start mid-block");
                check(cs_bit, exp_bit(VEC[v], 1'b0, f),
                      $sformatf("%s left idx %0d%s", field_tag(f), f, (f > 5) ? " R10" : ""));
                send(1'b1);
                check(blk_start, 1'b0, "R2 right never starts");
                check(cs_bit, exp_bit(VEC[v], 1'b1, f),
                      $sformatf("%s right idx %0d%s", field_tag(f), f, (f > 5) ? " R10" : ""));
            end
        end

        // R12: repeated left request inside frame 8 (category A5)
        cfg = VEC[0];
        for (int f = 0; f < 8; f++) begin
            send(1'b0);
            send(1'b1);
        end
        send(1'b0);
        check(cs_bit, 1'b1, "R12 first left idx 8");
        send(1'b0);
        check(cs_bit, 1'b1, "R12 repeated left idx 8");
        check(blk_start, 1'b0, "R12 repeated left no start");
        send(1'b1);
        check(cs_bit, 1'b1, "R12 right idx 8");
        send(1'b0);
        check(cs_bit, 1'b0, "R12 left idx 9");
        send(1'b1);
        send(1'b0);
        check(cs_bit, 1'b1, "R12 left idx 10");

        // R1: reset in mid-block
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_bit, 1'b0, "R1 mid-block reset cs_bit");
        check(blk_start, 1'b0, "R1 mid-block reset blk_start");
        send(1'b1);
        check(blk_start, 1'b0, "R11 idle right after reset");
        send(1'b0);
        check(blk_start, 1'b1, "R11 left after ignored right starts block");
        check(cs_bit, 1'b0, "R4 bit 0 after reset");

        finish_run();
    end

endmodule